// File: doc/BRIEF.md
# Chained DMA Tag Walker with Return Stack

This block is the address sequencer for one chained source DMA channel. Each time a new tag has been fetched and decoded, the surrounding channel logic presents the tag kind, the current tag address, the address field and the quadword count with a one-cycle start strobe. The walker computes the next data address and the next tag address. It maintains a two-entry return-address stack for subroutine-style call and return tags, and it reports whether the chain terminates at this tag.

Addresses are byte addresses, and one quadword is 16 bytes. The results are registered and are presented one cycle after the strobe, together with a one-cycle valid pulse. Between strobes the outputs hold their values. A stack-mode input selects whether the call and return kinds are honoured. The stack pointer and both stack slots are visible on outputs, so the channel can save and restore them. The stack is cleared only by reset.

Top module: `dma_chain_walker`

## Requirements
- R1: While reset is active (synchronous, active low), and in the first cycle after it, valid, end, both address outputs, the stack pointer and both stack slots are zero.
- R2: A start strobe in cycle N gives result_valid_o high in cycle N+1 only, with the updated outputs. Without a strobe, the address outputs, end flag and stack hold their values.
- R3: Kind 0 (reference-and-end) ends the chain. The data output takes the address field and the tag output takes the tag address, both unchanged.
- R4: Kind 1 (count) sets data to tag+16 and tag to tag+16+count*16, modulo 2^AW, and does not end the chain.
- R5: Kind 2 (next) sets data to tag+16 and tag to the address field, and does not end the chain.
- R6: Kinds 3 (reference) and 4 (reference with stall) set tag to tag+16, keep the address field as the data output, and do not end the chain.
- R7: Kind 5 (call) with stack mode on and pointer below 2 sets data to tag+16 and tag to the address field. It writes tag+16+count*16 into the slot indexed by the pointer and increments the pointer.
- R8: Kind 5 with stack mode on and pointer 2 ends the chain. It sets data to tag+16, keeps the tag address, and leaves the stack untouched.
- R9: Kind 6 (return) with stack mode on and pointer 1 or 2 sets data to tag+16. The tag output takes slot pointer-1, that slot is cleared to zero and the pointer decrements, so the slots pop in last-in first-out order.
- R10: Kind 6 with stack mode on and an empty stack ends the chain. It sets data to tag+16 and keeps the tag address.
- R11: Kind 7 (end) sets data to tag+16, keeps the tag address, and ends the chain.
- R12: With stack mode off, kinds 5 and 6 pass the address field and tag address through unchanged, do not end the chain, and leave the stack untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle strobe: tag fields are valid |
| stack_mode_i | input | 1 | 1 enables call/return handling |
| kind_i | input | 3 | Decoded tag kind (0..7) |
| tag_addr_i | input | AW | Address of the current tag |
| data_addr_i | input | AW | Address field carried by the tag |
| qw_count_i | input | QW | Quadword count of the tag |
| result_valid_o | output | 1 | One-cycle pulse when results are updated |
| chain_end_o | output | 1 | Chain terminates at this tag |
| data_addr_o | output | AW | Next data address |
| tag_addr_o | output | AW | Next tag address |
| stack_ptr_o | output | PW | Number of stacked return addresses |
| stack_slots_o | output | DEPTH*AW | Slot i at bits [i*AW +: AW] |

## Verification
On every cycle the checker confirms the one-cycle valid pulse, that the outputs hold between strobes, and that the stack pointer moves by exactly one on a legal call or return and never passes the depth. It also checks that the stack is frozen and no end is raised when stack mode is off, and that terminating kinds raise the end flag. The exact address arithmetic of each kind only shows in the bench's scenarios: the count wrap, the last-in first-out pop order with slot clearing, and the overflow and underflow terminations.

// File: rtl/dcw_pkg.sv
// Package: shared tag-kind encoding for the chained DMA tag walker.
// Assumes a 3-bit decoded kind supplied by the tag decoder.
package dcw_pkg;
    typedef enum logic [2:0] {
        KIND_REF_END   = 3'd0,
        KIND_COUNT     = 3'd1,
        KIND_NEXT      = 3'd2,
        KIND_REF       = 3'd3,
        KIND_REF_STALL = 3'd4,
        KIND_CALL      = 3'd5,
        KIND_RETURN    = 3'd6,
        KIND_END       = 3'd7
    } tag_kind_e;

    localparam int unsigned QWORD_BYTES = 16;
endpackage

// File: rtl/dcw_addr_calc.sv
// Module: dcw_addr_calc
// Purely combinational next-address decision for one tag. It produces
// the next data/tag addresses, the end flag and the stack push/pop requests.
// Assumes the stack reports full/empty/legal-pop status for the current pointer.
module dcw_addr_calc
    import dcw_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned QW = 16
) (
    input  logic [2:0]    kind_i,
    input  logic          stack_mode_i,
    input  logic [AW-1:0] tag_addr_i,
    input  logic [AW-1:0] data_addr_i,
    input  logic [QW-1:0] qw_count_i,
    input  logic          stack_full_i,
    input  logic          pop_ok_i,
    input  logic [AW-1:0] pop_addr_i,
    output logic [AW-1:0] next_data_o,
    output logic [AW-1:0] next_tag_o,
    output logic          end_o,
    output logic          push_o,
    output logic          pop_o,
    output logic [AW-1:0] push_addr_o
);
    localparam logic [AW-1:0] STEP = AW'(QWORD_BYTES);

    logic [AW-1:0] after_tag;
    logic [AW-1:0] after_data;

    // Address of the quadword after the tag and the address after its payload.
    always_comb begin
        after_tag  = tag_addr_i + STEP;
        after_data = after_tag + (AW'(qw_count_i) << 4);
    end

    // Per-kind selection of the next addresses and stack actions.
    always_comb begin
        next_data_o = data_addr_i;
        next_tag_o  = tag_addr_i;
        end_o       = 1'b0;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        push_addr_o = after_data;
        unique case (tag_kind_e'(kind_i))
            KIND_REF_END: end_o = 1'b1;
            KIND_COUNT: begin
                next_data_o = after_tag;
                next_tag_o  = after_data;
            end
            KIND_NEXT: begin
                next_data_o = after_tag;
                next_tag_o  = data_addr_i;
            end
            KIND_REF, KIND_REF_STALL: next_tag_o = after_tag;
            KIND_CALL: begin
                if (stack_mode_i) begin
                    next_data_o = after_tag;
                    if (stack_full_i) begin
                        end_o = 1'b1;
                    end else begin
                        next_tag_o = data_addr_i;
                        push_o     = 1'b1;
                    end
                end
            end
            KIND_RETURN: begin
                if (stack_mode_i) begin
                    next_data_o = after_tag;
                    if (pop_ok_i) begin
                        next_tag_o = pop_addr_i;
                        pop_o      = 1'b1;
                    end else begin
                        end_o = 1'b1;
                    end
                end
            end
            KIND_END: begin
                next_data_o = after_tag;
                end_o       = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dcw_ret_stack.sv
// Module: dcw_ret_stack
// Return-address stack of DEPTH slots with a fill pointer. Push writes
// slot[ptr] and increments; pop reads slot[ptr-1], clears it and decrements.
// Assumes the caller never pushes when full nor pops when pop_ok_o is low.
module dcw_ret_stack #(
    parameter int unsigned AW    = 32,
    parameter int unsigned DEPTH = 2,
    localparam int unsigned PW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_i,
    input  logic                pop_i,
    input  logic [AW-1:0]       push_addr_i,
    output logic [PW-1:0]       ptr_o,
    output logic                full_o,
    output logic                pop_ok_o,
    output logic [AW-1:0]       top_addr_o,
    output logic [DEPTH*AW-1:0] slots_o
);
    logic [PW-1:0] ptr_q;
    logic [AW-1:0] slot_q [DEPTH];

    // Fill pointer: up on push, down on pop.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr_q <= '0;
        else if (push_i) ptr_q <= ptr_q + 1'b1;
        else if (pop_i)  ptr_q <= ptr_q - 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Slot i: written by a push at pointer i, cleared by a pop at pointer i+1.
        always_ff @(posedge clk) begin
            if (!rst_n)                                slot_q[i] <= '0;
            else if (push_i && ptr_q == PW'(i))        slot_q[i] <= push_addr_i;
            else if (pop_i && ptr_q == PW'(i + 1))     slot_q[i] <= '0;
        end
        assign slots_o[i*AW +: AW] = slot_q[i];
    end

    // Status and top-of-stack read for the current pointer.
    always_comb begin
        full_o     = (ptr_q >= PW'(DEPTH));
        pop_ok_o   = (ptr_q != '0) && (ptr_q <= PW'(DEPTH));
        top_addr_o = '0;
        for (int j = 0; j < DEPTH; j++) begin
            if (ptr_q == PW'(j + 1)) top_addr_o = slot_q[j];
        end
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/dma_chain_walker.sv
// Module: dma_chain_walker
// Top of the chained-DMA tag walker. On start_i it evaluates one tag,
// commits the next data/tag addresses and stack update on the next edge,
// and pulses result_valid_o for one cycle. Outputs hold between strobes.
// Assumes tag fields are stable while start_i is high.
module dma_chain_walker #(
    parameter int unsigned AW    = 32,
    parameter int unsigned QW    = 16,
    parameter int unsigned DEPTH = 2,
    localparam int unsigned PW   = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                stack_mode_i,
    input  logic [2:0]          kind_i,
    input  logic [AW-1:0]       tag_addr_i,
    input  logic [AW-1:0]       data_addr_i,
    input  logic [QW-1:0]       qw_count_i,
    output logic                result_valid_o,
    output logic                chain_end_o,
    output logic [AW-1:0]       data_addr_o,
    output logic [AW-1:0]       tag_addr_o,
    output logic [PW-1:0]       stack_ptr_o,
    output logic [DEPTH*AW-1:0] stack_slots_o
);
    logic          full, pop_ok, push_req, pop_req, end_d;
    logic [AW-1:0] pop_addr, push_addr, data_d, tag_d;

    dcw_addr_calc #(.AW(AW), .QW(QW)) u_calc (
        .kind_i       (kind_i),
        .stack_mode_i (stack_mode_i),
        .tag_addr_i   (tag_addr_i),
        .data_addr_i  (data_addr_i),
        .qw_count_i   (qw_count_i),
        .stack_full_i (full),
        .pop_ok_i     (pop_ok),
        .pop_addr_i   (pop_addr),
        .next_data_o  (data_d),
        .next_tag_o   (tag_d),
        .end_o        (end_d),
        .push_o       (push_req),
        .pop_o        (pop_req),
        .push_addr_o  (push_addr)
    );

    dcw_ret_stack #(.AW(AW), .DEPTH(DEPTH)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (start_i && push_req),
        .pop_i       (start_i && pop_req),
        .push_addr_i (push_addr),
        .ptr_o       (stack_ptr_o),
        .full_o      (full),
        .pop_ok_o    (pop_ok),
        .top_addr_o  (pop_addr),
        .slots_o     (stack_slots_o)
    );

    // Result registers: load on start, hold otherwise; valid is a one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_valid_o <= 1'b0;
            chain_end_o    <= 1'b0;
            data_addr_o    <= '0;
            tag_addr_o     <= '0;
        end else begin
            result_valid_o <= start_i;
            if (start_i) begin
                chain_end_o <= end_d;
                data_addr_o <= data_d;
                tag_addr_o  <= tag_d;
            end
        end
    end
endmodule

// File: rtl/dcw_checker.sv
// Module: dcw_checker
// Cycle-by-cycle properties of the walker, attached by bind to the top.
module dcw_checker #(
    parameter int unsigned AW    = 32,
    parameter int unsigned DEPTH = 2,
    parameter int unsigned PW    = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          stack_mode_i,
    input logic [2:0]    kind_i,
    input logic [AW-1:0] tag_addr_i,
    input logic [AW-1:0] data_addr_i,
    input logic          result_valid_o,
    input logic          chain_end_o,
    input logic [AW-1:0] data_addr_o,
    input logic [AW-1:0] tag_addr_o,
    input logic [PW-1:0] stack_ptr_o
);
    a_r2_valid_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> result_valid_o);

    a_r2_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !result_valid_o);

    a_r2_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(data_addr_o) && $stable(tag_addr_o) && $stable(chain_end_o)
                      && $stable(stack_ptr_o)));

    a_r3_ref_end_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && kind_i == 3'd0) |=> (chain_end_o && data_addr_o == $past(data_addr_i)));

    a_r6_ref_step: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (kind_i == 3'd3 || kind_i == 3'd4))
        |=> (tag_addr_o == $past(tag_addr_i) + AW'(16) && !chain_end_o));

    a_r7_push_step: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stack_mode_i && kind_i == 3'd5 && stack_ptr_o < PW'(DEPTH))
        |=> (stack_ptr_o == $past(stack_ptr_o) + 1'b1 && !chain_end_o));

    a_r8_overflow_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stack_mode_i && kind_i == 3'd5 && stack_ptr_o == PW'(DEPTH))
        |=> (chain_end_o && $stable(stack_ptr_o)));

    a_r9_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stack_mode_i && kind_i == 3'd6 && stack_ptr_o != '0)
        |=> (stack_ptr_o == $past(stack_ptr_o) - 1'b1 && !chain_end_o));

    a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ptr_o <= PW'(DEPTH));

    a_r10_underflow_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && stack_mode_i && kind_i == 3'd6 && stack_ptr_o == '0)
        |=> (chain_end_o && stack_ptr_o == '0));

    a_r12_mode_off_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !stack_mode_i && (kind_i == 3'd5 || kind_i == 3'd6))
        |=> (!chain_end_o && $stable(stack_ptr_o) && tag_addr_o == $past(tag_addr_i)));
endmodule

bind dma_chain_walker dcw_checker #(.AW(AW), .DEPTH(DEPTH), .PW(PW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .stack_mode_i   (stack_mode_i),
    .kind_i         (kind_i),
    .tag_addr_i     (tag_addr_i),
    .data_addr_i    (data_addr_i),
    .result_valid_o (result_valid_o),
    .chain_end_o    (chain_end_o),
    .data_addr_o    (data_addr_o),
    .tag_addr_o     (tag_addr_o),
    .stack_ptr_o    (stack_ptr_o)
);

// File: tb/dma_chain_walker_tb.sv
module dma_chain_walker_tb;
    localparam int AW = 32;
    localparam int QW = 16;
    localparam int DEPTH = 2;
    localparam int PW = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic                mode = 1'b1;
    logic [2:0]          kind = '0;
    logic [AW-1:0]       tag_in = '0;
    logic [AW-1:0]       data_in = '0;
    logic [QW-1:0]       qwc = '0;
    logic                valid, cend;
    logic [AW-1:0]       data_out, tag_out;
    logic [PW-1:0]       ptr;
    logic [DEPTH*AW-1:0] slots;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dma_chain_walker #(.AW(AW), .QW(QW), .DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .stack_mode_i(mode),
        .kind_i(kind), .tag_addr_i(tag_in), .data_addr_i(data_in), .qw_count_i(qwc),
        .result_valid_o(valid), .chain_end_o(cend), .data_addr_o(data_out),
        .tag_addr_o(tag_out), .stack_ptr_o(ptr), .stack_slots_o(slots)
    );

    typedef struct packed {
        logic [2:0]  kind;
        logic        mode;
        logic [31:0] tag;
        logic [31:0] data;
        logic [15:0] qwc;
        logic [31:0] exp_data;
        logic [31:0] exp_tag;
        logic        exp_end;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 1'b1, 32'h100,      32'h800, 16'd3, 32'h800, 32'h100, 1'b1},
        '{3'd1, 1'b1, 32'h100,      32'h800, 16'd3, 32'h110, 32'h140, 1'b0},
        '{3'd2, 1'b1, 32'h200,      32'h900, 16'd5, 32'h210, 32'h900, 1'b0},
        '{3'd3, 1'b1, 32'h300,      32'hA00, 16'd2, 32'hA00, 32'h310, 1'b0},
        '{3'd4, 1'b1, 32'h400,      32'hB00, 16'd2, 32'hB00, 32'h410, 1'b0},
        '{3'd7, 1'b1, 32'h500,      32'hC00, 16'd4, 32'h510, 32'h500, 1'b1},
        '{3'd1, 1'b1, 32'hFFFFFFF0, 32'h0,   16'd1, 32'h0,   32'h10,  1'b0},
        '{3'd5, 1'b0, 32'h600,      32'hD00, 16'd1, 32'hD00, 32'h600, 1'b0},
        '{3'd6, 1'b0, 32'h700,      32'hE00, 16'd1, 32'hE00, 32'h700, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one tag for one cycle; return at the negedge after the committing edge.
    task automatic issue(input logic [2:0] k, input logic m, input logic [31:0] t,
                         input logic [31:0] d, input logic [15:0] q);
        @(negedge clk);
        kind = k; mode = m; tag_in = t; data_in = d; qwc = q; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        // R1: reset state.
        check("R1 valid", 32'(valid), 32'd0);
        check("R1 end", 32'(cend), 32'd0);
        check("R1 data", data_out, 32'd0);
        check("R1 tag", tag_out, 32'd0);
        check("R1 ptr", 32'(ptr), 32'd0);
        check("R1 slots", slots[31:0] | slots[63:32], 32'd0);

        // Table walk: R3 R4 R5 R6 R11 R12 per vector.
        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].kind, VECS[i].mode, VECS[i].tag, VECS[i].data, VECS[i].qwc);
            check("R2 valid pulse", 32'(valid), 32'd1);
            check("R3-R6/R11/R12 data", data_out, VECS[i].exp_data);
            check("R3-R6/R11/R12 tag", tag_out, VECS[i].exp_tag);
            check("R3-R6/R11/R12 end", 32'(cend), 32'(VECS[i].exp_end));
            check("R12 ptr untouched", 32'(ptr), 32'd0);
        end

        // R2: hold with no strobe.
        @(negedge clk);
        check("R2 valid drops", 32'(valid), 32'd0);
        check("R2 data holds", data_out, 32'h700 + 32'h700);
        check("R2 tag holds", tag_out, 32'h700);

        // R7: two pushes.
        do_reset();
        issue(3'd5, 1'b1, 32'h1000, 32'h2000, 16'd2);
        check("R7 data", data_out, 32'h1010);
        check("R7 tag", tag_out, 32'h2000);
        check("R7 slot0", slots[31:0], 32'h1030);
        check("R7 ptr", 32'(ptr), 32'd1);
        check("R7 end", 32'(cend), 32'd0);
        issue(3'd5, 1'b1, 32'h2000, 32'h3000, 16'd1);
        check("R7 slot1", slots[63:32], 32'h2020);
        check("R7 ptr2", 32'(ptr), 32'd2);

        // R8: overflow ends, stack untouched.
        issue(3'd5, 1'b1, 32'h3000, 32'h4000, 16'd0);
        check("R8 end", 32'(cend), 32'd1);
        check("R8 data", data_out, 32'h3010);
        check("R8 tag", tag_out, 32'h3000);
        check("R8 ptr", 32'(ptr), 32'd2);
        check("R8 slot0", slots[31:0], 32'h1030);
        check("R8 slot1", slots[63:32], 32'h2020);

        // R12: mode off with full stack: nothing moves.
        issue(3'd6, 1'b0, 32'h4400, 32'h4800, 16'd0);
        check("R12 ret off data", data_out, 32'h4800);
        check("R12 ret off tag", tag_out, 32'h4400);
        check("R12 ret off end", 32'(cend), 32'd0);
        check("R12 ret off ptr", 32'(ptr), 32'd2);
        check("R12 ret off slot1", slots[63:32], 32'h2020);

        // R9: pops in LIFO order, slots cleared.
        issue(3'd6, 1'b1, 32'h5000, 32'h0, 16'd0);
        check("R9 data", data_out, 32'h5010);
        check("R9 tag pop1", tag_out, 32'h2020);
        check("R9 slot1 cleared", slots[63:32], 32'd0);
        check("R9 ptr1", 32'(ptr), 32'd1);
        check("R9 end", 32'(cend), 32'd0);
        issue(3'd6, 1'b1, 32'h6000, 32'h0, 16'd0);
        check("R9 tag pop0", tag_out, 32'h1030);
        check("R9 slot0 cleared", slots[31:0], 32'd0);
        check("R9 ptr0", 32'(ptr), 32'd0);

        // R10: underflow ends.
        issue(3'd6, 1'b1, 32'h7000, 32'h9000, 16'd0);
        check("R10 end", 32'(cend), 32'd1);
        check("R10 data", data_out, 32'h7010);
        check("R10 tag", tag_out, 32'h7000);
        check("R10 ptr", 32'(ptr), 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule